// File: doc/BRIEF.md
# Registered Bus Exchanger (one narrow port, two paired wide halves)

This block exchanges data between a single narrow port (the A side) and a wide side split into two equal halves (port 1 and port 2). Going outward, successive words arriving on the A side are captured into the half chosen by its own active-low capture enable. Two words that arrive on consecutive cycles can therefore be presented together as one double-width word, with port 2 as the upper half and port 1 as the lower half. Coming back, one return register samples either half's input on every clock edge, as chosen by a select line, and presents that value on the A side.

Every port is modelled as separate input data, output data and drive-enable signals. Each drive enable comes from an active-low output-enable request that is registered, so a port's drive state changes only at a clock edge. An active-low asynchronous reset clears all data registers and turns all drives off.

Top module: `reg_bus_exchanger`

## Requirements
- R1: While `rst_n` is low, `half1_out`, `half2_out` and `a_out` are 0, and `a_drive`, `half1_drive` and `half2_drive` are 0.
- R2: On a rising edge with `cap1_n` = 0, `half1_out` takes the value of `a_in`.
- R3: On a rising edge with `cap2_n` = 0, `half2_out` takes the value of `a_in`, so two words captured on successive edges appear together as {`half2_out`, `half1_out`}.
- R4: On a rising edge with a capture enable at 1, that half's output keeps its previous value whatever `a_in` is.
- R5: On every rising edge, `a_out` takes `half1_in` when `ret_sel` = 1 and `half2_in` when `ret_sel` = 0.
- R6: Each drive output equals the inverse of its output-enable request (`a_oe_n`, `half1_oe_n`, `half2_oe_n`) as sampled at the previous rising edge; a change of a request shows on the drive only after the next edge.
- R7: A half's input data reaches the return register regardless of that half's drive state.
- R8: A capture into a half and a return-register load on the same edge both take effect, each from the values present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 12 | Data arriving on the A side |
| a_out | output | 12 | Return register contents |
| a_drive | output | 1 | A side drive enable, registered |
| half1_in | input | 12 | Data arriving on port 1 |
| half1_out | output | 12 | Port 1 capture register |
| half1_drive | output | 1 | Port 1 drive enable, registered |
| half2_in | input | 12 | Data arriving on port 2 |
| half2_out | output | 12 | Port 2 capture register |
| half2_drive | output | 1 | Port 2 drive enable, registered |
| cap1_n | input | 1 | Active-low capture enable for port 1 |
| cap2_n | input | 1 | Active-low capture enable for port 2 |
| ret_sel | input | 1 | Return select: 1 picks port 1, 0 picks port 2 |
| a_oe_n | input | 1 | Active-low drive request for the A side |
| half1_oe_n | input | 1 | Active-low drive request for port 1 |
| half2_oe_n | input | 1 | Active-low drive request for port 2 |

## Verification
The outward capture and the return load can fall on the same clock edge, and so can a change of a drive request. The bench provokes this by asserting a capture enable while it presents fresh data on both halves' inputs and flips the select and drive requests in the same cycle. Each path is then judged on its own, from a model that takes every input from before the edge: the captured half must hold the A word, the return register must hold the selected half's input, and the drive outputs must follow the requests only from that edge on.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned XCHG_W = 12;
  localparam int unsigned XCHG_HALVES = 2;

  // Return path choice: sel=1 takes port 1, sel=0 takes port 2.
  function automatic logic [XCHG_W-1:0] pick_return(input logic sel,
                                                    input logic [XCHG_W-1:0] p1,
                                                    input logic [XCHG_W-1:0] p2);
    return sel ? p1 : p2;
  endfunction
endpackage

// File: rtl/xchg_capture.sv
module xchg_capture #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         cap_fire
);
  assign cap_fire = !cap_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (cap_fire) q <= d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_n |=> q == $past(d));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_n |=> $stable(q));
endmodule

// File: rtl/xchg_return.sv
module xchg_return #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic [W-1:0] p1,
  input  logic [W-1:0] p2,
  output logic [W-1:0] q
);
  import xchg_pkg::*;
  logic [W-1:0] ret_next;
  assign ret_next = pick_return(sel, p1, p2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else q <= ret_next;
  end

  p_ret_p1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> q == $past(p1));
  p_ret_p2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> q == $past(p2));
endmodule

// File: rtl/xchg_drive.sv
module xchg_drive #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] oe_n,
  output logic [N-1:0] drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive <= '0;
    else drive <= ~oe_n;
  end

  p_drive_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drive == ~$past(oe_n));
  p_reset_off_r1: assert property (@(posedge clk)
    !rst_n |-> drive == '0);
endmodule

// File: rtl/reg_bus_exchanger.sv
module reg_bus_exchanger #(
  parameter int unsigned W = xchg_pkg::XCHG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] half1_in,
  output logic [W-1:0] half1_out,
  output logic         half1_drive,
  input  logic [W-1:0] half2_in,
  output logic [W-1:0] half2_out,
  output logic         half2_drive,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic         ret_sel,
  input  logic         a_oe_n,
  input  logic         half1_oe_n,
  input  logic         half2_oe_n
);
  localparam int unsigned NH = xchg_pkg::XCHG_HALVES;
  localparam int unsigned ND = NH + 1;

  logic [NH-1:0]        cap_n_v;
  logic [NH-1:0]        cap_fire_v;
  logic [NH-1:0][W-1:0] half_q;
  logic [ND-1:0]        oe_n_v;
  logic [ND-1:0]        drive_v;

  assign cap_n_v = {cap2_n, cap1_n};

  for (genvar h = 0; h < NH; h++) begin : g_half
    xchg_capture #(.W(W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_n    (cap_n_v[h]),
      .d        (a_in),
      .q        (half_q[h]),
      .cap_fire (cap_fire_v[h])
    );
  end

  xchg_return #(.W(W)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ret_sel),
    .p1    (half1_in),
    .p2    (half2_in),
    .q     (a_out)
  );

  assign oe_n_v = {half2_oe_n, half1_oe_n, a_oe_n};

  xchg_drive #(.N(ND)) u_drv (
    .clk   (clk),
    .rst_n (rst_n),
    .oe_n  (oe_n_v),
    .drive (drive_v)
  );

  assign half1_out   = half_q[0];
  assign half2_out   = half_q[1];
  assign a_drive     = drive_v[0];
  assign half1_drive = drive_v[1];
  assign half2_drive = drive_v[2];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (half1_out == '0 && half2_out == '0 && a_out == '0));
  p_same_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire_v[0] && ret_sel) |=> (half1_out == $past(a_in) && a_out == $past(half1_in)));
  p_word_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire_v[1] && !cap_fire_v[0]) |=> (half2_out == $past(a_in) && $stable(half1_out)));
endmodule

// File: tb/tb_reg_bus_exchanger.sv
`timescale 1ns/1ps
module tb_reg_bus_exchanger;
  localparam int W = 12;

  typedef struct {
    logic [W-1:0] b1, b2, a;
    logic         da, d1, d2;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, half1_in = '0, half2_in = '0;
  logic [W-1:0] a_out, half1_out, half2_out;
  logic a_drive, half1_drive, half2_drive;
  logic cap1_n = 1'b1, cap2_n = 1'b1, ret_sel = 1'b0;
  logic a_oe_n = 1'b1, half1_oe_n = 1'b1, half2_oe_n = 1'b1;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  logic [W-1:0] m_b1 = '0, m_b2 = '0, m_a = '0;

  always #2.5 clk = ~clk;

  reg_bus_exchanger #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .half1_in(half1_in), .half1_out(half1_out), .half1_drive(half1_drive),
    .half2_in(half2_in), .half2_out(half2_out), .half2_drive(half2_drive),
    .cap1_n(cap1_n), .cap2_n(cap2_n), .ret_sel(ret_sel),
    .a_oe_n(a_oe_n), .half1_oe_n(half1_oe_n), .half2_oe_n(half2_oe_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic [W-1:0] a, input logic c1, input logic c2,
                      input logic sel, input logic [W-1:0] p1, input logic [W-1:0] p2,
                      input logic oa, input logic o1, input logic o2, input string tag);
    exp_t e;
    @(negedge clk); #1;
    a_in = a; cap1_n = c1; cap2_n = c2; ret_sel = sel;
    half1_in = p1; half2_in = p2;
    a_oe_n = oa; half1_oe_n = o1; half2_oe_n = o2;
    if (!c1) m_b1 = a;
    if (!c2) m_b2 = a;
    m_a = sel ? p1 : p2;
    e.b1 = m_b1; e.b2 = m_b2; e.a = m_a;
    e.da = !oa; e.d1 = !o1; e.d2 = !o2; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares results one edge after each stimulus.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " half1"}, 32'(half1_out), 32'(e.b1));
      check({e.tag, " half2"}, 32'(half2_out), 32'(e.b2));
      check({e.tag, " ret"},   32'(a_out),     32'(e.a));
      check({e.tag, " drives"}, {29'd0, a_drive, half1_drive, half2_drive},
            {29'd0, e.da, e.d1, e.d2});
    end
  end

  initial begin
    fork
      begin
        #3;
        // R1: reset state
        check("R1 data", {half1_out, half2_out, 8'd0}, 32'd0);
        check("R1 ret", 32'(a_out), 32'd0);
        check("R1 drives", {29'd0, a_drive, half1_drive, half2_drive}, 32'd0);
        @(negedge clk); #1 rst_n = 1'b1;
        // R2: capture first word into port 1
        step(12'h123, 0, 1, 0, 12'h000, 12'h000, 1, 1, 1, "R2");
        // R3: second word into port 2, pair forms {456,123}
        step(12'h456, 1, 0, 0, 12'h000, 12'h000, 1, 1, 1, "R3");
        // R4: both enables high, new A data ignored
        step(12'hFFF, 1, 1, 0, 12'h000, 12'h000, 1, 1, 1, "R4");
        step(12'h0F0, 1, 1, 1, 12'h000, 12'h000, 1, 1, 1, "R4 hold");
        // R5: return select both ways
        step(12'h000, 1, 1, 1, 12'h5A5, 12'hA5A, 1, 1, 1, "R5 sel1");
        step(12'h000, 1, 1, 0, 12'h5A5, 12'hA5A, 1, 1, 1, "R5 sel0");
        // R6: drive requests follow one edge later, one at a time
        step(12'h000, 1, 1, 0, 12'h000, 12'h777, 0, 1, 1, "R6 a");
        step(12'h000, 1, 1, 0, 12'h000, 12'h777, 1, 0, 1, "R6 p1");
        step(12'h000, 1, 1, 0, 12'h000, 12'h777, 1, 1, 0, "R6 p2");
        // R7: port 1 driving off yet its input returns; port 2 driving on
        step(12'h000, 1, 1, 1, 12'h3C3, 12'h111, 1, 1, 0, "R7 p1");
        step(12'h000, 1, 1, 0, 12'h3C3, 12'h2D2, 0, 0, 1, "R7 p2");
        // R8: capture and return on the same edge, plus drive flips
        step(12'hBEE, 0, 1, 1, 12'hCAB, 12'h999, 1, 1, 0, "R8 a");
        step(12'hDAD, 1, 0, 0, 12'h888, 12'hFAD, 0, 0, 1, "R8 b");
        step(12'h321, 0, 0, 1, 12'h654, 12'h987, 0, 0, 0, "R8 both");
        step(12'h000, 1, 1, 0, 12'h000, 12'h000, 1, 1, 1, "R4 final");
        repeat (3) @(negedge clk);
        #1;
        check("scoreboard empty", 32'(sb.size()), 32'd0);
      end
      begin
        repeat (2000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule